// File: doc/BRIEF.md
# Sink Termination Detect Poller

This block runs one sequencer per lane of a multi-lane differential repeater. Each sequencer decides whether its lane presents low-ohm (50 ohm) termination or only weak high-ohm pull-ups. It then keeps probing for a far-end 50 ohm load, using a fixed-length detection window, until it finds one. An analog comparator outside the block reports `det_hit` for each lane. The block reads that result only at the closing tick of each window.

A free-running `tick` pulse from a shared timebase measures time. `WIN_TICKS` ticks make up one detection window, and the default of 5000 ticks of 1 us gives 5 ms. When a lane sees a load, it switches to low-ohm termination straight away and sets its `found` flag. It raises `ready` after a further `SETTLE_TICKS` ticks, which gives the termination time to settle. The lanes run independently of each other. The following inputs all force a lane back to high-ohm termination, and each one restarts or holds the lane's sequence in its own way: global power enable, the per-lane enable, the per-lane detect power-down bit and the per-lane restart bit.

Top module: `term_detect_poller`

## Requirements
- R1: After synchronous reset, every lane has `term_lo`=0 (high-ohm), `found`=0 and `ready`=0.
- R2: While `pwr_en` is 0, every lane shows `term_lo`=0, `found`=0 and `ready`=0 from the next clock edge on. After `pwr_en` returns to 1, polling restarts: one edge enters polling, and the first window then begins with its count at zero.
- R3: A polling lane counts the cycles that have `tick`=1. It samples `det_hit` only on the tick that completes a window of `WIN_TICKS` ticks. If `det_hit`=1 on that tick, `term_lo` and `found` go to 1 at that edge. `det_hit` at any other time has no effect.
- R4: If `det_hit`=0 on the closing tick, a new window of `WIN_TICKS` ticks starts. This repeats with no limit.
- R5: Each lane's outputs depend only on that lane's own `lane_en`, `det_pd`, `lane_rst` and `det_hit`, together with the shared `tick` and `pwr_en`.
- R6: After detection, `ready` goes to 1 on the `SETTLE_TICKS`-th following tick, and `term_lo` stays at 1 for as long as `ready` is 1.
- R7: A lane whose `lane_en` is 0 behaves as in R2 from the next edge on. The other lanes are not affected.
- R8: While a lane's `det_pd` is 1, the lane shows `term_lo`=0 and `ready`=0. Its window count is frozen and `found` keeps its value. When `det_pd` is released during polling, counting resumes from the held count. When it is released after detection, a fresh window starts.
- R9: A one-cycle `lane_rst`=1 clears `found` and restarts that lane from the start of its first window.
- R10: Windows and the settle time advance only on cycles with `tick`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase pulse, one cycle wide |
| pwr_en | input | 1 | Global power enable |
| lane_en | input | LANES | Per-lane enable |
| det_pd | input | LANES | Per-lane detect power-down (freeze) |
| lane_rst | input | LANES | Per-lane sequence restart |
| det_hit | input | LANES | Per-lane comparator result, 1 = load present |
| term_lo | output | LANES | 1 = 50 ohm termination, 0 = high-ohm pull-ups |
| found | output | LANES | Load detected since the last restart |
| ready | output | LANES | Lane terminated and settled |

## Verification
The bench targets the cycle on which a window closes. A design with an off-by-one counter would sample `det_hit` one tick early or one tick late, and a design that samples `det_hit` at every tick would switch termination in the middle of a window. Detect power-down is applied at random during polling and during settling. A design that clears the count instead of freezing it, or that drops `found` while frozen, would show a late or missing `term_lo` after release. Short drops of power enable, lane disables and restarts are mixed in, one lane at a time. Any leakage between lanes, or a restart that does not clear `found`, would show as a mismatch on a neighbouring lane or on the same lane.

// File: rtl/tdp_pkg.sv
package tdp_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_POLL   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_READY  = 2'd3
  } tdp_state_e;
endpackage

// File: rtl/tdp_win_cnt.sv
module tdp_win_cnt #(
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic [CW-1:0] last,
  output logic          at_end
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (adv)   cnt_q <= cnt_q + 1'b1;
  end

  assign at_end = (cnt_q == last);
endmodule

// File: rtl/tdp_lane.sv
module tdp_lane
  import tdp_pkg::*;
#(
  parameter int WIN_TICKS    = 5000,
  parameter int SETTLE_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic pwr_en,
  input  logic lane_en,
  input  logic det_pd,
  input  logic lane_rst,
  input  logic det_hit,
  output logic term_lo,
  output logic found,
  output logic ready
);
  localparam int MAXT = (WIN_TICKS > SETTLE_TICKS) ? WIN_TICKS : SETTLE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] WIN_LAST = CW'(WIN_TICKS - 1);
  localparam logic [CW-1:0] SET_LAST = CW'(SETTLE_TICKS - 1);

  tdp_state_e    state_q, state_d;
  logic          found_d;
  logic          clr, adv, at_end;
  logic [CW-1:0] last;

  assign last = (state_q == ST_POLL) ? WIN_LAST : SET_LAST;

  tdp_win_cnt #(.CW(CW)) cnt_i (
    .clk(clk), .rst(rst), .clr(clr), .adv(adv), .last(last), .at_end(at_end)
  );

  always_comb begin
    state_d = state_q;
    found_d = found;
    clr     = 1'b0;
    adv     = 1'b0;
    if (!pwr_en || !lane_en) begin
      state_d = ST_OFF;
      found_d = 1'b0;
      clr     = 1'b1;
    end else if (lane_rst) begin
      state_d = ST_POLL;
      found_d = 1'b0;
      clr     = 1'b1;
    end else begin
      unique case (state_q)
        ST_OFF: begin
          state_d = ST_POLL;
          clr     = 1'b1;
        end
        ST_POLL: begin
          if (!det_pd && tick) begin
            if (at_end) begin
              clr = 1'b1;
              if (det_hit) begin
                state_d = ST_SETTLE;
                found_d = 1'b1;
              end
            end else begin
              adv = 1'b1;
            end
          end
        end
        ST_SETTLE: begin
          if (det_pd) begin
            state_d = ST_POLL;
            clr     = 1'b1;
          end else if (tick) begin
            if (at_end) begin
              state_d = ST_READY;
              clr     = 1'b1;
            end else begin
              adv = 1'b1;
            end
          end
        end
        ST_READY: begin
          if (det_pd) begin
            state_d = ST_POLL;
            clr     = 1'b1;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      found   <= 1'b0;
      term_lo <= 1'b0;
      ready   <= 1'b0;
    end else begin
      state_q <= state_d;
      found   <= found_d;
      term_lo <= (state_d == ST_SETTLE) || (state_d == ST_READY);
      ready   <= (state_d == ST_READY);
    end
  end
endmodule

// File: rtl/term_detect_poller.sv
module term_detect_poller #(
  parameter int LANES        = 4,
  parameter int WIN_TICKS    = 5000,
  parameter int SETTLE_TICKS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             pwr_en,
  input  logic [LANES-1:0] lane_en,
  input  logic [LANES-1:0] det_pd,
  input  logic [LANES-1:0] lane_rst,
  input  logic [LANES-1:0] det_hit,
  output logic [LANES-1:0] term_lo,
  output logic [LANES-1:0] found,
  output logic [LANES-1:0] ready
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tdp_lane #(
      .WIN_TICKS(WIN_TICKS),
      .SETTLE_TICKS(SETTLE_TICKS)
    ) lane_i (
      .clk(clk), .rst(rst), .tick(tick), .pwr_en(pwr_en),
      .lane_en(lane_en[g]), .det_pd(det_pd[g]), .lane_rst(lane_rst[g]),
      .det_hit(det_hit[g]), .term_lo(term_lo[g]), .found(found[g]),
      .ready(ready[g])
    );
  end
endmodule

// File: rtl/tdp_checker.sv
module tdp_checker #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             pwr_en,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] det_pd,
  input logic [LANES-1:0] lane_rst,
  input logic [LANES-1:0] det_hit,
  input logic [LANES-1:0] term_lo,
  input logic [LANES-1:0] found,
  input logic [LANES-1:0] ready
);
  p_power_off_r2: assert property (@(posedge clk) disable iff (rst)
    !pwr_en |=> (term_lo == '0) && (found == '0) && (ready == '0));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    p_hit_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
      $rose(term_lo[g]) |-> $past(det_hit[g] && tick));
    p_ready_term_r6: assert property (@(posedge clk) disable iff (rst)
      ready[g] |-> term_lo[g]);
    p_ready_after_term_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ready[g]) |-> $past(term_lo[g]));
    p_lane_off_r7: assert property (@(posedge clk) disable iff (rst)
      !lane_en[g] |=> !found[g] && !term_lo[g] && !ready[g]);
    p_pd_high_ohm_r8: assert property (@(posedge clk) disable iff (rst)
      det_pd[g] |=> !term_lo[g] && !ready[g]);
    p_restart_r9: assert property (@(posedge clk) disable iff (rst)
      lane_rst[g] |=> !found[g] && !term_lo[g]);
    p_ready_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
      $rose(ready[g]) |-> $past(tick));
  end
endmodule

bind term_detect_poller tdp_checker #(.LANES(LANES)) chk_i (
  .clk(clk), .rst(rst), .tick(tick), .pwr_en(pwr_en), .lane_en(lane_en),
  .det_pd(det_pd), .lane_rst(lane_rst), .det_hit(det_hit),
  .term_lo(term_lo), .found(found), .ready(ready)
);

// File: tb/term_detect_poller_tb_top.sv
module term_detect_poller_tb_top;
  localparam int L   = 4;
  localparam int WIN = 6;
  localparam int SET = 3;

  logic clk = 1'b0;
  logic rst, tick, pwr_en;
  logic [L-1:0] lane_en, det_pd, lane_rst, det_hit;
  logic [L-1:0] term_lo, found, ready;

  int checks = 0;
  int fails  = 0;
  int mst[L];
  int mcnt[L];
  bit mfound[L];

  always #2.5 clk = ~clk;

  term_detect_poller #(.LANES(L), .WIN_TICKS(WIN), .SETTLE_TICKS(SET)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .pwr_en(pwr_en), .lane_en(lane_en),
    .det_pd(det_pd), .lane_rst(lane_rst), .det_hit(det_hit),
    .term_lo(term_lo), .found(found), .ready(ready)
  );

  // Reference: 0 off, 1 polling, 2 settling, 3 ready (R2..R10)
  task automatic model_step();
    for (int i = 0; i < L; i++) begin
      if (rst || !pwr_en || !lane_en[i]) begin
        mst[i] = 0; mcnt[i] = 0; mfound[i] = 0;
      end else if (lane_rst[i]) begin
        mst[i] = 1; mcnt[i] = 0; mfound[i] = 0;
      end else begin
        case (mst[i])
          0: begin mst[i] = 1; mcnt[i] = 0; end
          1: if (!det_pd[i] && tick) begin
               if (mcnt[i] == WIN - 1) begin
                 mcnt[i] = 0;
                 if (det_hit[i]) begin mst[i] = 2; mfound[i] = 1; end
               end else mcnt[i]++;
             end
          2: if (det_pd[i]) begin mst[i] = 1; mcnt[i] = 0; end
             else if (tick) begin
               if (mcnt[i] == SET - 1) begin mst[i] = 3; mcnt[i] = 0; end
               else mcnt[i]++;
             end
          default: if (det_pd[i]) begin mst[i] = 1; mcnt[i] = 0; end
        endcase
      end
    end
  endtask

  function automatic logic [2:0] exp_out(int i);
    return {mst[i] >= 2, mfound[i], mst[i] == 3};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    for (int i = 0; i < L; i++)
      check($sformatf("R3/R4/R5/R6/R8 lane%0d {term,found,ready}", i),
            {29'd0, term_lo[i], found[i], ready[i]}, {29'd0, exp_out(i)});
  endtask

  // drive at negedge, then advance the model for the coming posedge
  task automatic cyc();
    model_step();
    @(negedge clk);
    compare_model();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; tick = 1'b0; pwr_en = 1'b0;
    lane_en = '1; det_pd = '0; lane_rst = '0; det_hit = '0;
    repeat (3) @(negedge clk);
    model_step();
    check("R1 reset term_lo", 32'(term_lo), 0);
    check("R1 reset found", 32'(found), 0);
    check("R1 reset ready", 32'(ready), 0);

    // Directed: windows close on the 6th tick, settle on the 3rd
    rst = 1'b0; pwr_en = 1'b1; tick = 1'b1; det_hit = '1;
    for (int e = 1; e <= 10; e++) begin
      cyc();
      if (e == 6)  check("R3 no termination before window end", 32'(term_lo), 0);
      if (e == 7)  check("R3 termination at window end", 32'(term_lo), 32'hF);
      if (e == 9)  check("R6 ready not yet", 32'(ready), 0);
      if (e == 10) check("R6 ready after settle", 32'(ready), 32'hF);
    end

    // Directed: lane 1 misses first window, others idle on tick=0 (R4, R10)
    lane_rst = '1; cyc(); lane_rst = '0;
    det_hit = 4'b0001; tick = 1'b1;
    for (int e = 1; e <= 6; e++) cyc();
    check("R4 miss keeps high-ohm", 32'(term_lo), 32'h1);
    det_hit = 4'b0010; tick = 1'b0;
    repeat (10) cyc();
    check("R10 no progress without tick", 32'(term_lo), 32'h1);
    tick = 1'b1;
    for (int e = 1; e <= 6; e++) cyc();
    check("R4 second window detects", 32'(term_lo), 32'h3);

    // Directed: pwr_en low clears all (R2), lane_en low clears one (R7)
    lane_en = 4'b1110; cyc();
    check("R7 disabled lane off", 32'(found), 32'h2);
    lane_en = '1; pwr_en = 1'b0; cyc();
    check("R2 power low clears found", 32'(found), 0);
    pwr_en = 1'b1;

    // Random phase with directed restarts mixed in (R5, R8, R9)
    for (int n = 0; n < 20000; n++) begin
      tick    = ($urandom % 2) == 0;
      det_hit = 4'($urandom);
      for (int i = 0; i < L; i++) begin
        det_hit[i] = det_hit[i] & (($urandom % 3) == 0);
        det_pd[i]  = ($urandom % 25) == 0;
        lane_rst[i] = ($urandom % 300) == 0;
        lane_en[i]  = ($urandom % 400) != 0;
      end
      pwr_en = ($urandom % 700) != 0;
      cyc();
    end
    det_pd = '0; lane_rst = '0; lane_en = '1; pwr_en = 1'b1;
    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule